// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block joins two 18-bit buses, A and B, with a non-inverting path in each direction. Each path holds one storage bit per data bit. That storage acts as a transparent latch while the path's latch-enable is high. It acts as a rising-edge register, loaded from the path's strobe input, while the latch-enable is low. The path's output drives the opposite bus through a three-state driver. The A-to-B driver is enabled by a high level and the B-to-A driver is enabled by a low level.

The block is a synchronous model. The strobe inputs are sampled on the system clock, and a strobe "rising edge" is a cycle in which the strobe is high after being low on the previous clock. Reset is synchronous and active low. Reset clears both stores and keeps both buses undriven for as long as it is held. When both directions are enabled at once, the block does not arbitrate. It raises a contention output instead.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While rst_n is low at a rising clock both stores become zero. During reset neither bus is driven and contention stays low. After release, an enabled direction with its latch-enable low drives all zeros.
- R2: bus_b is driven only while ab_oe is 1 (active high) and reset is released; otherwise bus_b is high impedance.
- R3: bus_a is driven only while ba_oe_n is 0 (active low) and reset is released; otherwise bus_a is high impedance.
- R4: With a direction's latch-enable at 1, its output equals its input bus in the same cycle, with no clock delay.
- R5: With the latch-enable at 0 and no strobe rising edge, the store keeps its value. This holds whether the strobe is steady at 1 or at 0, and whatever the input bus does.
- R6: With the latch-enable at 0, a strobe rising edge (strobe 1 at a clock, 0 at the clock before) loads the input bus into the store. The new value appears on the output after that clock. A strobe held at 1 loads only once.
- R7: When the latch-enable goes from 1 to 0, the store keeps the input value sampled at the last clock on which the latch-enable was 1.
- R8: Storage loads and holds while the output is disabled, and the stored value appears as soon as the output is enabled.
- R9: contention is 1 exactly when both directions are enabled (ab_oe=1, ba_oe_n=0) outside reset.
- R10: The path is non-inverting and bit-independent: bit i of the output equals bit i of the source for every pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch-enable (1 = transparent) |
| ab_strb | input | 1 | A-to-B load strobe, rising edge loads |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch-enable (1 = transparent) |
| ba_strb | input | 1 | B-to-A load strobe, rising edge loads |
| bus_a | inout | 18 | A-side bus |
| bus_b | inout | 18 | B-side bus |
| contention | output | 1 | Both directions enabled at once |

## Verification
The bench checks the latch-enable falling cycle. A design that captures the value after the fall instead of the last transparent value would show the new input on the output. It holds a strobe high for several cycles; a level-sensitive load would keep tracking the bus. It loads a store with the output disabled and then enables the output, which catches stores gated by the enable. Whenever a bus should be undriven, the bench drives a pattern onto that bus and reads it back. Any wrong driver or swapped enable polarity therefore shows up as a corrupted readback.

// File: rtl/xcvr_pkg.sv
// Shared types for the bidirectional latch-register transceiver.
package xcvr_pkg;
    localparam int XCVR_WIDTH = 18;

    // Control bundle of one direction
    typedef struct packed {
        logic le;     // 1 = transparent
        logic strb;   // load strobe, rising edge loads when le = 0
        logic oe;     // output enable as seen at the pin (raw polarity)
    } lane_ctl_t;
endpackage

// File: rtl/xcvr_bit_cell.sv
// One storage bit of a direction. Loads d when load is high; clears on reset.
// Assumes load is already qualified by the lane (latch-enable or strobe edge).
module xcvr_bit_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);
    // Storage flop with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/xcvr_lane.sv
// One transfer direction: per-bit storage, strobe edge detect, transparent
// bypass and driver enable. OE_HIGH selects the enable pin polarity.
// Assumes the strobe is synchronous to clk.
module xcvr_lane #(
    parameter int W       = xcvr_pkg::XCVR_WIDTH,
    parameter bit OE_HIGH = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         src,
    input  xcvr_pkg::lane_ctl_t  ctl,
    output logic [W-1:0]         q,
    output logic                 drive
);
    logic         strb_q;
    logic         strb_rise;
    logic         load;
    logic         oe_act;
    logic [W-1:0] stored;

    // Previous strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= ctl.strb;
    end

    // Load qualifier: transparent phase or strobe rising edge
    always_comb begin
        strb_rise = ctl.strb & ~strb_q;
        load      = ctl.le | strb_rise;
    end

    // One storage cell per data bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        xcvr_bit_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .d     (src[i]),
            .q     (stored[i])
        );
    end

    // Enable polarity chosen by parameter
    if (OE_HIGH) begin : g_oe_hi
        assign oe_act = ctl.oe;
    end else begin : g_oe_lo
        assign oe_act = ~ctl.oe;
    end

    // Output select and driver enable (never drive in reset)
    always_comb begin
        q     = ctl.le ? src : stored;
        drive = oe_act & rst_n;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> stored == '0);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.le && !(ctl.strb && !strb_q)) |=> stored == $past(stored));
    assert_edge_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.le && ctl.strb && !strb_q) |=> stored == $past(src));
    assert_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.le |=> stored == $past(src));
endmodule

// File: rtl/xcvr_contention.sv
// Flags both directions driving at the same time. Does not arbitrate.
module xcvr_contention (
    input  logic drive_ab,
    input  logic drive_ba,
    output logic flag
);
    // Both drivers active
    always_comb flag = drive_ab & drive_ba;
endmodule

// File: rtl/bidir_latch_xcvr.sv
// Top: 18-bit bidirectional transceiver with latch/register storage per
// direction. A-to-B enable is active high, B-to-A enable is active low.
// Assumes the buses are three-state nets shared with external drivers.
module bidir_latch_xcvr #(
    parameter int W = xcvr_pkg::XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ab_oe,
    input  logic         ab_le,
    input  logic         ab_strb,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_strb,
    inout  wire  [W-1:0] bus_a,
    inout  wire  [W-1:0] bus_b,
    output logic         contention
);
    xcvr_pkg::lane_ctl_t ctl_ab, ctl_ba;
    logic [W-1:0] q_ab, q_ba;
    logic         drv_ab, drv_ba;

    // Pack per-direction controls
    always_comb begin
        ctl_ab = '{le: ab_le, strb: ab_strb, oe: ab_oe};
        ctl_ba = '{le: ba_le, strb: ba_strb, oe: ba_oe_n};
    end

    xcvr_lane #(.W(W), .OE_HIGH(1'b1)) u_ab (
        .clk(clk), .rst_n(rst_n), .src(bus_a), .ctl(ctl_ab),
        .q(q_ab), .drive(drv_ab)
    );

    xcvr_lane #(.W(W), .OE_HIGH(1'b0)) u_ba (
        .clk(clk), .rst_n(rst_n), .src(bus_b), .ctl(ctl_ba),
        .q(q_ba), .drive(drv_ba)
    );

    xcvr_contention u_guard (
        .drive_ab(drv_ab), .drive_ba(drv_ba), .flag(contention)
    );

    // Three-state drivers onto the opposite buses
    assign bus_b = drv_ab ? q_ab : {W{1'bz}};
    assign bus_a = drv_ba ? q_ba : {W{1'bz}};

    assert_quiet_in_reset_R1: assert property (@(posedge clk)
        !rst_n |-> !drv_ab && !drv_ba && !contention);
    assert_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
        contention |-> (ab_oe && !ba_oe_n));
endmodule

// File: tb/bidir_latch_xcvr_test.sv
module bidir_latch_xcvr_test;
    localparam int W = 18;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ab_oe = 1'b0, ab_le = 1'b0, ab_strb = 1'b0;
    logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_strb = 1'b0;
    logic [W-1:0] tb_a = '0, tb_b = '0;
    logic tb_a_on, tb_b_on;
    wire  [W-1:0] bus_a, bus_b;
    logic contention;

    int total = 0, bad = 0;
    bit finished = 0;
    string cur_tag = "R1";

    // reference model state
    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic p_ab = 1'b0, p_ba = 1'b0;
    logic [W-1:0] cap_sa, cap_sb;
    logic cap_rst, cap_ab_le, cap_ab_strb, cap_ba_le, cap_ba_strb;

    always #4 clk = ~clk;

    // bench drives a bus only when the model says the block should not
    assign tb_a_on = !(rst_n && !ba_oe_n);
    assign tb_b_on = !(rst_n && ab_oe);
    assign bus_a = tb_a_on ? tb_a : {W{1'bz}};
    assign bus_b = tb_b_on ? tb_b : {W{1'bz}};

    bidir_latch_xcvr uut (
        .clk(clk), .rst_n(rst_n),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_strb(ab_strb),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_strb(ba_strb),
        .bus_a(bus_a), .bus_b(bus_b), .contention(contention)
    );

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, shortly before the rising edge
    always @(negedge clk) begin
        logic a_drv, b_drv;
        logic [W-1:0] ea, eb, sa, sb;
        #3;
        a_drv = rst_n && !ba_oe_n;
        b_drv = rst_n && ab_oe;
        sa = tb_a; sb = tb_b; ea = tb_a; eb = tb_b;
        if (b_drv && !a_drv) begin
            eb = ab_le ? sa : m_ab;
            sb = eb;
        end else if (a_drv && !b_drv) begin
            ea = ba_le ? sb : m_ba;
            sa = ea;
        end
        if (!(a_drv && b_drv)) begin
            check(cur_tag, "bus_a", bus_a, ea);
            check(cur_tag, "bus_b", bus_b, eb);
        end
        check(cur_tag, "contention", {{(W-1){1'b0}}, contention},
              {{(W-1){1'b0}}, (a_drv && b_drv)});
        cap_sa = sa; cap_sb = sb; cap_rst = rst_n;
        cap_ab_le = ab_le; cap_ab_strb = ab_strb;
        cap_ba_le = ba_le; cap_ba_strb = ba_strb;
    end

    // model update at the edge, from values captured before it
    always @(posedge clk) begin
        if (!cap_rst) begin
            m_ab = '0; m_ba = '0; p_ab = 1'b0; p_ba = 1'b0;
        end else begin
            if (cap_ab_le || (cap_ab_strb && !p_ab)) m_ab = cap_sa;
            if (cap_ba_le || (cap_ba_strb && !p_ba)) m_ba = cap_sb;
            p_ab = cap_ab_strb;
            p_ba = cap_ba_strb;
        end
    end

    task automatic step(string tag, logic aoe, logic ale, logic astb,
                        logic boe_n, logic ble, logic bstb,
                        logic [W-1:0] av, logic [W-1:0] bv);
        @(negedge clk);
        cur_tag = tag;
        ab_oe = aoe; ab_le = ale; ab_strb = astb;
        ba_oe_n = boe_n; ba_le = ble; ba_strb = bstb;
        tb_a = av; tb_b = bv;
    endtask

    initial begin
        // R1: reset with both enables asserted and values on both buses
        rst_n = 1'b0;
        step("R1", 1, 1, 1, 0, 1, 1, 18'h1234, 18'h0abcd);
        step("R1", 1, 1, 1, 0, 1, 1, 18'h2222, 18'h1111);
        step("R1", 0, 0, 0, 1, 0, 0, 18'h3c3c, 18'h0c3c3);
        @(negedge clk); rst_n = 1'b1;
        step("R2", 0, 0, 0, 1, 0, 0, 18'h155aa, 18'h2aa55);
        step("R1", 1, 0, 0, 1, 0, 0, 18'h3ffff, 18'h0);
        // R4 / R10: transparent with several patterns
        step("R4", 1, 1, 0, 1, 0, 0, 18'h15555, 18'h0);
        step("R10", 1, 1, 0, 1, 0, 0, 18'h2aaaa, 18'h0);
        step("R10", 1, 1, 0, 1, 0, 0, ONES, 18'h0);
        for (int i = 0; i < W; i += 5)
            step("R10", 1, 1, 0, 1, 0, 0, 18'h1 << i, 18'h0);
        step("R4", 1, 1, 0, 1, 0, 0, 18'h0f0f0, 18'h0);
        // R7: fall of latch-enable keeps last transparent value
        step("R7", 1, 0, 0, 1, 0, 0, 18'h30303, 18'h0);
        step("R7", 1, 0, 0, 1, 0, 0, 18'h01010, 18'h0);
        // R5: hold, strobe steady low then steady high
        step("R5", 1, 0, 0, 1, 0, 0, 18'h2d2d2, 18'h0);
        // R6: rising edge loads once even though strobe stays high
        step("R6", 1, 0, 1, 1, 0, 0, 18'h1e1e1, 18'h0);
        step("R6", 1, 0, 1, 1, 0, 0, 18'h00777, 18'h0);
        step("R5", 1, 0, 1, 1, 0, 0, 18'h3a5a5, 18'h0);
        step("R5", 1, 0, 0, 1, 0, 0, 18'h05a5a, 18'h0);
        step("R6", 1, 0, 1, 1, 0, 0, 18'h12345, 18'h0);
        step("R6", 1, 0, 0, 1, 0, 0, 18'h0, 18'h0);
        // R2: disable A-to-B, bus_b must read back the bench value
        step("R2", 0, 0, 0, 1, 0, 0, 18'h0, 18'h3cccc);
        step("R2", 0, 1, 0, 1, 0, 0, 18'h11111, 18'h03333);
        // R3: B-to-A path, active-low enable
        step("R3", 0, 0, 0, 0, 1, 0, 18'h0, 18'h2468a);
        step("R3", 0, 0, 0, 0, 1, 0, 18'h0, 18'h13579);
        step("R7", 0, 0, 0, 0, 0, 0, 18'h0, 18'h3ffff);
        step("R6", 0, 0, 0, 0, 0, 1, 18'h0, 18'h0beef);
        step("R5", 0, 0, 0, 0, 0, 1, 18'h0, 18'h0dead);
        step("R3", 0, 0, 0, 1, 0, 0, 18'h2bbbb, 18'h0);
        step("R3", 0, 0, 0, 1, 1, 0, 18'h04444, 18'h1aaaa);
        // R8: load A-to-B while disabled, then enable
        step("R8", 0, 0, 0, 1, 0, 0, 18'h0, 18'h0);
        step("R8", 0, 0, 1, 1, 0, 0, 18'h2f00f, 18'h1);
        step("R8", 0, 0, 0, 1, 0, 0, 18'h00ff0, 18'h2);
        step("R8", 1, 0, 0, 1, 0, 0, 18'h00ff0, 18'h0);
        step("R8", 1, 0, 0, 1, 0, 0, 18'h3f0f0, 18'h0);
        // R9: both directions enabled, stores held
        step("R9", 1, 0, 0, 0, 0, 0, 18'h0, 18'h0);
        step("R9", 1, 0, 0, 0, 0, 0, 18'h0, 18'h0);
        step("R9", 0, 0, 0, 0, 0, 0, 18'h0, 18'h0);
        step("R9", 1, 0, 0, 1, 0, 0, 18'h0, 18'h0);
        // R1: reset mid-run clears stores
        @(negedge clk); rst_n = 1'b0;
        step("R1", 1, 0, 0, 0, 0, 0, 18'h15151, 18'h2a2a2);
        @(negedge clk); rst_n = 1'b1;
        step("R1", 1, 0, 0, 1, 0, 0, 18'h3ffff, 18'h0);
        step("R1", 0, 0, 0, 0, 0, 0, 18'h0, 18'h3ffff);
        step("R1", 0, 0, 0, 1, 0, 0, 18'h0, 18'h0);
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule